// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Standby Wakeup

This block turns a serial asynchronous bit stream into characters of 8 or 9 data bits. Each bit lasts sixteen ticks of an oversampling tick input, and is decided by a majority vote over three samples taken around the middle of the bit. Each accepted character is presented on a parallel data output with a one-cycle strobe. Six sticky status flags report data-ready, idle line, overrun, noise, framing error and parity error. A single clear input drops all six flags at once.

For multi-drop links the receiver has a standby state that software enters with a request pulse. In standby, characters are taken off the line but leave no trace on the outputs. Hardware leaves standby by itself when the chosen wakeup condition appears. That condition is either an idle line between messages, or a character whose top data bit is 1 (an address mark). A loop mode takes the serial data from an internal transmit line instead of the external pin, for self-test.

Top module: `uart_rx_wake`

## Requirements
- R1: A character is a 0 start bit, then 8 data bits (`nine_bit_i`=0) or 9 data bits (`nine_bit_i`=1), least significant bit first, then a stop bit. When a character is accepted, `rx_data_o` holds it with bit 8 at 0 in 8-bit mode, `data_ready_o` is set, and `rx_valid_o` is high for exactly one cycle.
- R2: Each bit spans 16 ticks. Ticks are counted from the first low sample of the start bit as index 0. The bit value is the majority of the samples at indices 7, 8 and 9. If these three samples do not all agree in any bit of a character, `noise_o` is set. A glitch at any other index has no effect. A start bit whose vote is 1 is dropped as a false start and yields no character.
- R3: A stop bit that votes 0 sets `frame_err_o`. The character is still delivered.
- R4: With `parity_en_i`=1, the top data bit (bit 7 or bit 8) is the parity bit. `parity_err_o` is set when the number of ones among all data bits is odd (`parity_odd_i`=0) or even (`parity_odd_i`=1). With `parity_en_i`=0 the flag is never set.
- R5: A character that completes while `data_ready_o` is 1, with `status_clr_i` low in that cycle, sets `overrun_o`. The character is dropped: `rx_data_o` and `data_ready_o` keep their values and no strobe is given.
- R6: With `rx_en_i`=0 the receiver samples nothing. No flag, strobe or standby state changes, except that `status_clr_i` still clears the flags.
- R7: With `loop_en_i`=1 the receiver takes its data from `loop_txd_i` and ignores `rxd_i`.
- R8: After any low sample, `idle_o` is set once the line has stayed 1 for 160 ticks in 8-bit mode, or 176 ticks in 9-bit mode. It is set again only after a later low sample. It is not set in standby.
- R9: A pulse on `wake_req_i` while enabled sets `standby_o`. In standby, characters give no strobe and set no flag, except the waking character described in R11.
- R10: With `wake_sel_i`=0, an idle condition as in R8 clears `standby_o` without setting `idle_o`. The next character is received normally.
- R11: With `wake_sel_i`=1, a character received in standby whose top data bit (bit 7, or bit 8 in 9-bit mode) is 1 clears `standby_o` and is received normally. A character whose top bit is 0 is dropped.
- R12: After reset all six flags, `standby_o` and `rx_data_o` are 0. A pulse on `status_clr_i` clears all six flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | External serial data line, idle high |
| loop_txd_i | input | 1 | Internal transmit line used in loop mode |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| rx_en_i | input | 1 | Receiver enable |
| loop_en_i | input | 1 | Take data from the internal transmit line |
| nine_bit_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| parity_en_i | input | 1 | Parity check enable |
| parity_odd_i | input | 1 | 1: odd parity, 0: even parity |
| wake_req_i | input | 1 | Pulse: enter standby |
| wake_sel_i | input | 1 | Wakeup condition, 0 idle line, 1 address mark |
| status_clr_i | input | 1 | Pulse: clear all status flags |
| rx_data_o | output | 9 | Last accepted character |
| rx_valid_o | output | 1 | One-cycle strobe per accepted character |
| standby_o | output | 1 | Receiver is in standby |
| data_ready_o | output | 1 | Unread character present |
| idle_o | output | 1 | Idle line seen |
| overrun_o | output | 1 | Character lost to an unread one |
| noise_o | output | 1 | Disagreeing mid-bit samples seen |
| frame_err_o | output | 1 | Stop bit read as 0 |
| parity_err_o | output | 1 | Parity mismatch |

## Verification
Every 8-bit value and a strided set of 9-bit values are sent. This separates bit order, width selection and data-bit alignment. Single-cycle glitches are placed at a voting index and at a non-voting index, and one short low pulse imitates a start bit. Together these separate the majority vote from the noise flag and from false-start rejection. The same frame is sent with the line idle and with standby requested under each wakeup method. Top bits of 0 and 1 show which characters wake the receiver. Idle gaps are sampled just before and just after the 8-bit and 9-bit character times, which separates the two idle limits.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int CHAR_BITS = 9;

    typedef logic [CHAR_BITS-1:0] rx_char_t;

    typedef struct packed {
        logic ready;
        logic idle;
        logic overrun;
        logic noise;
        logic framing;
        logic parity;
    } rx_flags_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxw_line_sel.sv
module rxw_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic loop_txd_i,
    input  logic loop_en_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = SYNC_STAGES'({sync_q, rxd_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    // loop path is internal and already synchronous
    assign line_o = loop_en_i ? loop_txd_i : sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rxw_frame.sv
module rxw_frame
    import rxw_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     tick_i,
    input  logic     line_i,
    input  logic     nine_bit_i,
    output logic     done_o,
    output rx_char_t char_o,
    output logic     stop_o,
    output logic     noise_o
);
    localparam int SUB_W = $clog2(OVERSAMPLE);
    localparam logic [SUB_W-1:0] S_LO  = SUB_W'(OVERSAMPLE / 2 - 1);
    localparam logic [SUB_W-1:0] S_MID = SUB_W'(OVERSAMPLE / 2);
    localparam logic [SUB_W-1:0] S_HI  = SUB_W'(OVERSAMPLE / 2 + 1);
    localparam logic [SUB_W-1:0] S_END = SUB_W'(OVERSAMPLE - 1);

    typedef struct packed {
        logic             busy;
        logic [SUB_W-1:0] sub;
        logic [3:0]       bitn;
        logic [1:0]       early;
        rx_char_t         shift;
        logic             noise;
        logic             done;
        rx_char_t         chr;
        logic             stop;
        logic             nz_out;
    } frame_t;

    frame_t st_d, st_q;
    logic   vote, nz;
    logic [3:0] stop_idx;

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        vote     = 1'b0;
        nz       = 1'b0;
        stop_idx = nine_bit_i ? 4'd10 : 4'd9;
        if (!en_i) begin
            st_d.busy = 1'b0;
        end else if (tick_i) begin
            if (!st_q.busy) begin
                if (!line_i) begin
                    st_d.busy  = 1'b1;
                    st_d.sub   = SUB_W'(1);
                    st_d.bitn  = 4'd0;
                    st_d.noise = 1'b0;
                end
            end else begin
                if (st_q.sub == S_LO)  st_d.early[0] = line_i;
                if (st_q.sub == S_MID) st_d.early[1] = line_i;
                if (st_q.sub == S_HI) begin
                    vote = maj3(st_q.early[0], st_q.early[1], line_i);
                    nz   = !((st_q.early[0] == st_q.early[1]) && (st_q.early[1] == line_i));
                    if (st_q.bitn == 4'd0) begin
                        if (vote) st_d.busy = 1'b0;    // false start
                        else      st_d.noise = nz;
                    end else if (st_q.bitn == stop_idx) begin
                        st_d.done   = 1'b1;
                        st_d.busy   = 1'b0;
                        st_d.stop   = vote;
                        st_d.nz_out = st_q.noise | nz;
                        st_d.chr    = nine_bit_i ? st_q.shift : {1'b0, st_q.shift[8:1]};
                    end else begin
                        st_d.shift = {vote, st_q.shift[8:1]};
                        st_d.noise = st_q.noise | nz;
                    end
                end
                if (st_q.sub == S_END) begin
                    st_d.sub  = '0;
                    st_d.bitn = st_q.bitn + 4'd1;
                end else begin
                    st_d.sub = st_q.sub + SUB_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o  = st_q.done;
    assign char_o  = st_q.chr;
    assign stop_o  = st_q.stop;
    assign noise_o = st_q.nz_out;
endmodule

// File: rtl/rxw_idle.sv
module rxw_idle #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic line_i,
    input  logic nine_bit_i,
    output logic idle_o
);
    localparam int CNT_W = $clog2(11 * OVERSAMPLE + 1);
    localparam logic [CNT_W-1:0] LIM8 = CNT_W'(10 * OVERSAMPLE);
    localparam logic [CNT_W-1:0] LIM9 = CNT_W'(11 * OVERSAMPLE);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             evt;
    } idle_t;

    idle_t st_d, st_q;
    logic [CNT_W-1:0] limit, nxt;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        limit    = nine_bit_i ? LIM9 : LIM8;
        nxt      = st_q.cnt + CNT_W'(1);
        if (!en_i) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (tick_i) begin
            if (!line_i) begin
                st_d.armed = 1'b1;
                st_d.cnt   = '0;
            end else if (st_q.armed) begin
                if (nxt == limit) begin
                    st_d.evt   = 1'b1;
                    st_d.armed = 1'b0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = nxt;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_o = st_q.evt;
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
    import rxw_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    input  logic       loop_txd_i,
    input  logic       tick_i,
    input  logic       rx_en_i,
    input  logic       loop_en_i,
    input  logic       nine_bit_i,
    input  logic       parity_en_i,
    input  logic       parity_odd_i,
    input  logic       wake_req_i,
    input  logic       wake_sel_i,
    input  logic       status_clr_i,
    output logic [8:0] rx_data_o,
    output logic       rx_valid_o,
    output logic       standby_o,
    output logic       data_ready_o,
    output logic       idle_o,
    output logic       overrun_o,
    output logic       noise_o,
    output logic       frame_err_o,
    output logic       parity_err_o
);
    typedef struct packed {
        logic      standby;
        rx_char_t  data;
        rx_flags_t flg;
        logic      valid;
    } ctl_t;

    logic     line, done, stop_bit, chr_noise, idle_evt;
    rx_char_t chr;

    rxw_line_sel #(.SYNC_STAGES(SYNC_STAGES)) i_line (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .loop_txd_i(loop_txd_i),
        .loop_en_i(loop_en_i), .line_o(line)
    );

    rxw_frame #(.OVERSAMPLE(OVERSAMPLE)) i_frame (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en_i), .tick_i(tick_i), .line_i(line),
        .nine_bit_i(nine_bit_i), .done_o(done), .char_o(chr), .stop_o(stop_bit),
        .noise_o(chr_noise)
    );

    rxw_idle #(.OVERSAMPLE(OVERSAMPLE)) i_idle (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en_i), .tick_i(tick_i), .line_i(line),
        .nine_bit_i(nine_bit_i), .idle_o(idle_evt)
    );

    ctl_t ctl_d, ctl_q;
    logic top_bit, accept;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        top_bit     = nine_bit_i ? chr[8] : chr[7];
        accept      = !ctl_q.standby || (wake_sel_i && top_bit);
        if (status_clr_i) ctl_d.flg = '0;
        if (rx_en_i) begin
            if (idle_evt) begin
                if (ctl_q.standby) begin
                    if (!wake_sel_i) ctl_d.standby = 1'b0;
                end else begin
                    ctl_d.flg.idle = 1'b1;
                end
            end
            if (done && accept) begin
                ctl_d.standby = 1'b0;
                if (ctl_d.flg.ready) begin
                    ctl_d.flg.overrun = 1'b1;
                end else begin
                    ctl_d.data        = chr;
                    ctl_d.flg.ready   = 1'b1;
                    ctl_d.valid       = 1'b1;
                    ctl_d.flg.framing = ctl_d.flg.framing | !stop_bit;
                    ctl_d.flg.noise   = ctl_d.flg.noise | chr_noise;
                    ctl_d.flg.parity  = ctl_d.flg.parity
                                      | (parity_en_i & ((^chr) ^ parity_odd_i));
                end
            end
            if (wake_req_i) ctl_d.standby = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rx_data_o    = ctl_q.data;
    assign rx_valid_o   = ctl_q.valid;
    assign standby_o    = ctl_q.standby;
    assign data_ready_o = ctl_q.flg.ready;
    assign idle_o       = ctl_q.flg.idle;
    assign overrun_o    = ctl_q.flg.overrun;
    assign noise_o      = ctl_q.flg.noise;
    assign frame_err_o  = ctl_q.flg.framing;
    assign parity_err_o = ctl_q.flg.parity;
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_en_i,
    input logic wake_req_i,
    input logic wake_sel_i,
    input logic status_clr_i,
    input logic rx_valid_o,
    input logic standby_o,
    input logic data_ready_o,
    input logic idle_o,
    input logic overrun_o,
    input logic noise_o,
    input logic frame_err_o,
    input logic parity_err_o
);
    logic [5:0] flags;
    assign flags = {data_ready_o, idle_o, overrun_o, noise_o, frame_err_o, parity_err_o};

    assert_valid_sets_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> data_ready_o);

    assert_overrun_blocks_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o && !status_clr_i |=> !rx_valid_o);

    assert_off_holds_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i && !status_clr_i |=> $stable(flags) && $stable(standby_o) && !rx_valid_o);

    assert_idle_standby_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o && !wake_sel_i |=> !rx_valid_o);

    assert_accept_leaves_standby_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !standby_o || $past(wake_req_i));

    assert_reset_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == 6'd0) && !standby_o);
endmodule

bind uart_rx_wake rxw_checker i_rxw_checker (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .wake_req_i(wake_req_i),
    .wake_sel_i(wake_sel_i), .status_clr_i(status_clr_i), .rx_valid_o(rx_valid_o),
    .standby_o(standby_o), .data_ready_o(data_ready_o), .idle_o(idle_o),
    .overrun_o(overrun_o), .noise_o(noise_o), .frame_err_o(frame_err_o),
    .parity_err_o(parity_err_o)
);

// File: tb/test_uart_rx_wake.sv
module test_uart_rx_wake;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd_v = 1'b1, loop_v = 1'b1;
    logic rx_en = 1'b1, loop_en = 1'b0, nine = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic wake_req = 1'b0, wake_sel = 1'b0, status_clr = 1'b0;
    logic [8:0] rx_data;
    logic rx_valid, standby, ready, idle, overrun, noise, ferr, perr;
    int checks = 0, errors = 0, vcount = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    uart_rx_wake i_uart_rx_wake (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd_v), .loop_txd_i(loop_v), .tick_i(1'b1),
        .rx_en_i(rx_en), .loop_en_i(loop_en), .nine_bit_i(nine), .parity_en_i(par_en),
        .parity_odd_i(par_odd), .wake_req_i(wake_req), .wake_sel_i(wake_sel),
        .status_clr_i(status_clr), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .standby_o(standby), .data_ready_o(ready), .idle_o(idle), .overrun_o(overrun),
        .noise_o(noise), .frame_err_o(ferr), .parity_err_o(perr)
    );

    always @(negedge clk) if (rst_n && rx_valid) vcount++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic b, input bit to_loop);
        if (to_loop) loop_v = b; else rxd_v = b;
    endtask

    // gbit: frame bit index to glitch (0 = start), gsamp: cycle within that bit
    task automatic send_frame(input logic [8:0] val, input bit nine9, input logic stop_v,
                              input int gbit, input int gsamp, input bit to_loop);
        int nb = nine9 ? 9 : 8;
        for (int b = 0; b < nb + 2; b++) begin
            logic lv;
            lv = (b == 0) ? 1'b0 : (b == nb + 1) ? stop_v : val[b-1];
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                drive((b == gbit && c == gsamp) ? ~lv : lv, to_loop);
            end
        end
        @(negedge clk);
        drive(1'b1, to_loop);
    endtask

    task automatic send(input logic [8:0] val);
        send_frame(val, nine, 1'b1, -1, 0, 1'b0);
        wait_cyc(6);
    endtask

    task automatic clear_flags;
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
    endtask

    task automatic pulse_wake;
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
    endtask

    initial begin
        int v0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // R12: reset state
        check("R12 reset flags", {ready, idle, overrun, noise, ferr, perr}, 0);
        check("R12 reset standby/data", {standby, rx_data}, 0);

        // R1: all 8-bit values
        for (int v = 0; v < 256; v++) begin
            clear_flags();
            v0 = vcount;
            send(9'(v));
            check("R1 data8", rx_data, v);
            check("R1 ready8", ready, 1);
            check("R1 one strobe", vcount - v0, 1);
            check("R3 R2 clean flags", {ferr, noise, perr}, 0);
        end
        // R1: 9-bit values, strided
        nine = 1'b1;
        for (int v = 0; v < 512; v += 5) begin
            clear_flags();
            send(9'(v));
            check("R1 data9", rx_data, v);
        end
        nine = 1'b0;

        // R2: glitch at voting index 7 of data bit 3 (frame bit 4)
        clear_flags();
        send_frame(9'h05A, 1'b0, 1'b1, 4, 7, 1'b0); wait_cyc(6);
        check("R2 vote keeps data", rx_data, 9'h05A);
        check("R2 noise at idx7", noise, 1);
        clear_flags();
        send_frame(9'h05A, 1'b0, 1'b1, 6, 9, 1'b0); wait_cyc(6);
        check("R2 noise at idx9", noise, 1);
        clear_flags();
        send_frame(9'h05A, 1'b0, 1'b1, 4, 3, 1'b0); wait_cyc(6);
        check("R2 off-center glitch ignored", {noise, rx_data}, {1'b0, 9'h05A});
        // R2: false start, 5 low cycles only
        clear_flags();
        v0 = vcount;
        @(negedge clk); rxd_v = 1'b0;
        wait_cyc(5); rxd_v = 1'b1;
        wait_cyc(200);
        check("R2 false start", {ready, 4'(vcount - v0)}, 0);
        clear_flags();

        // R3: stop bit 0
        send_frame(9'h033, 1'b0, 1'b0, -1, 0, 1'b0); wait_cyc(6);
        check("R3 framing", {ferr, rx_data}, {1'b1, 9'h033});
        wait_cyc(40);
        clear_flags();
        check("R12 clear", {ready, idle, overrun, noise, ferr, perr}, 0);

        // R4: parity
        par_en = 1'b1; par_odd = 1'b0;
        clear_flags(); send(9'h003); check("R4 even ok", perr, 0);
        clear_flags(); send(9'h007); check("R4 even bad", perr, 1);
        par_odd = 1'b1;
        clear_flags(); send(9'h007); check("R4 odd ok", perr, 0);
        clear_flags(); send(9'h003); check("R4 odd bad", perr, 1);
        par_en = 1'b0;

        // R5: overrun
        clear_flags();
        v0 = vcount;
        send(9'h011); send(9'h022);
        check("R5 overrun flag", overrun, 1);
        check("R5 data kept", rx_data, 9'h011);
        check("R5 single strobe", vcount - v0, 1);

        // R8: idle limits, last low sample 17 cycles before send() returns... use send_frame
        wait_cyc(200); clear_flags();
        send_frame(9'h000, 1'b0, 1'b1, -1, 0, 1'b0);
        wait_cyc(133); check("R8 idle8 early", idle, 0);
        wait_cyc(20);  check("R8 idle8 set", idle, 1);
        clear_flags();
        nine = 1'b1;
        send_frame(9'h000, 1'b1, 1'b1, -1, 0, 1'b0);
        wait_cyc(153); check("R8 idle9 early", idle, 0);
        wait_cyc(15);  check("R8 idle9 set", idle, 1);
        nine = 1'b0;
        clear_flags();
        wait_cyc(300); check("R8 idle once", idle, 0);

        // R6: receiver off
        rx_en = 1'b0;
        v0 = vcount;
        pulse_wake();
        send(9'h077);
        wait_cyc(200);
        check("R6 off no flags", {ready, idle, standby}, 0);
        check("R6 off no strobe", vcount - v0, 0);
        rx_en = 1'b1;
        wait_cyc(4);

        // R7: loop mode, external line held low
        rxd_v = 1'b0; loop_en = 1'b1;
        clear_flags();
        send_frame(9'h03C, 1'b0, 1'b1, -1, 0, 1'b1); wait_cyc(6);
        check("R7 loop data", {ready, ferr, rx_data}, {1'b1, 1'b0, 9'h03C});
        rxd_v = 1'b1; wait_cyc(5); loop_en = 1'b0;
        wait_cyc(200);

        // R9 R10: idle-line wakeup
        clear_flags();
        wake_sel = 1'b0;
        v0 = vcount;
        pulse_wake();
        check("R9 standby set", standby, 1);
        send_frame(9'h012, 1'b0, 1'b1, -1, 0, 1'b0);
        send_frame(9'h034, 1'b0, 1'b1, -1, 0, 1'b0);
        wait_cyc(6);
        check("R9 standby silent", {ready, 4'(vcount - v0), standby}, 1);
        wait_cyc(200);
        check("R10 idle wake", {standby, idle}, 0);
        send(9'h056);
        check("R10 after wake", {ready, rx_data}, {1'b1, 9'h056});

        // R11 R9: address-mark wakeup, 8-bit
        wait_cyc(200); clear_flags();
        wake_sel = 1'b1;
        pulse_wake();
        send(9'h045);
        check("R11 mark0 dropped", {ready, standby}, 2'b01);
        wait_cyc(200);
        check("R9 addr standby no idle", {idle, standby}, 2'b01);
        send(9'h0A5);
        check("R11 mark1 wakes", {ready, standby, rx_data}, {2'b10, 9'h0A5});
        // 9-bit address mark
        clear_flags();
        nine = 1'b1;
        pulse_wake();
        send(9'h0FF);
        check("R11 nine mark0", {ready, standby}, 2'b01);
        send(9'h155);
        check("R11 nine mark1", {ready, standby, rx_data}, {2'b10, 9'h155});
        nine = 1'b0;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule